// File: doc/BRIEF.md
# Synchronous Slave Serial Receiver

This block receives words over a clocked serial link in which a remote master owns the clock. The receiver never drives the clock; it brings the external clock and data lines into the system clock domain through a synchroniser, detects each falling edge of the serial clock, and takes one data bit there, least significant bit first. A word is 8 bits long, or 9 bits when the nine-bit mode is on. A finished word moves from the shift register into a two-entry holding queue. Software reads the head of that queue as an 8-bit data value plus a separate ninth-bit status.

The receiver runs only when the port enable is set, synchronous mode is selected, the clock-source select says the clock comes from outside, and the continuous-receive enable is set. The single-receive enable is accepted but has no effect in this mode. A receive-complete flag stays high while the queue holds data. It drives an interrupt request through an enable, and that request can also serve as a wake-up from an idle state, because nothing in the receive path depends on a running processor. When a word completes while the queue is full, the word is lost and a sticky overrun flag is raised. The overrun flag blocks further transfers and only clearing the continuous-receive enable removes it.

Top module: `sync_slave_rx`

## Requirements
- R1: After reset `data_out`, `ninth_out`, `overrun`, `rx_done` and `irq` are all 0.
- R2: In 8-bit mode (`nine_bit_en`=0) each falling edge of `ser_clk` takes `ser_dat` as the next bit, first bit into `data_out[0]`; after 8 bits the word is available on `data_out` and `ninth_out` is 0.
- R3: In 9-bit mode (`nine_bit_en`=1) a word is 9 bits; the first 8 go to `data_out[7:0]` and the ninth received bit is shown on `ninth_out`.
- R4: No word is received unless `port_en`=1, `sync_mode`=1, `clk_src_master`=0 and `cont_rx_en`=1 all hold.
- R5: `single_rx_en` has no effect: with `cont_rx_en`=1 words arrive whatever its value, and with `cont_rx_en`=0 setting it receives nothing.
- R6: Received words are queued in arrival order, up to 2 entries; `rx_done` is 1 while the queue is non-empty, a one-cycle `rd_pop` pulse removes the head, and `rx_done` falls after the last entry is removed. With the queue empty `data_out` and `ninth_out` read 0.
- R7: `irq` is 1 exactly when `rx_done` is 1 and `irq_en` is 1.
- R8: A word completing while the queue holds 2 entries is discarded and sets `overrun`; while `overrun` is 1 no further word enters the queue, and the stored words are unchanged.
- R9: `overrun` stays set until `cont_rx_en` is cleared, which clears it; clearing `cont_rx_en` also drops any partially received bits so that the next word starts at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | 1 selects clocked (synchronous) operation |
| clk_src_master | input | 1 | 1 = this side would generate the clock; must be 0 to receive |
| nine_bit_en | input | 1 | 1 selects 9-bit words |
| cont_rx_en | input | 1 | Continuous-receive enable; clearing it clears overrun |
| single_rx_en | input | 1 | Single-receive enable, ignored here |
| irq_en | input | 1 | Receive interrupt enable |
| ser_clk | input | 1 | Serial clock from the remote master |
| ser_dat | input | 1 | Serial data line |
| rd_pop | input | 1 | One-cycle pulse removing the queue head |
| data_out | output | 8 | Head word, 8 data bits |
| ninth_out | output | 1 | Head word, ninth bit |
| overrun | output | 1 | Sticky overrun error |
| rx_done | output | 1 | Queue holds at least one word |
| irq | output | 1 | Receive interrupt / wake-up request |

## Verification
The assertions assume the serial clock and data are slow against the system clock: each `ser_clk` level lasts several system cycles and `ser_dat` is stable across the falling edge, so the synchroniser never misses or duplicates an edge. They also assume `rd_pop` is pulsed only while `rx_done` is 1. The bench holds each serial level for at least three system cycles and changes data only while `ser_clk` is high. It pops only after it has seen `rx_done` set and never in a cycle when a word may be completing.

// File: rtl/sync_rx_pkg.sv
// Package: shared widths and the queued word type for the slave receiver.
// Assumes an 8-bit data word with one optional extension bit.
package sync_rx_pkg;
    localparam int WORD_W = 8;

    typedef struct packed {
        logic              ninth;
        logic [WORD_W-1:0] data;
    } rx_word_t;
endpackage

// File: rtl/rx_edge_sync.sv
// Module: rx_edge_sync
// Brings the external serial clock and data into the system clock domain
// through a chain of SYNC_STAGES flops and flags each falling edge of the
// serial clock. Assumes each serial level lasts longer than one system cycle.
module rx_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk_i,
    input  logic ser_dat_i,
    output logic fall_o,
    output logic dat_o
);
    logic [SYNC_STAGES-1:0] clk_chain;
    logic [SYNC_STAGES-1:0] dat_chain;
    logic                   clk_prev;

    // Shift both lines through their synchroniser chains.
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    clk_chain <= '1;
                    dat_chain <= '0;
                end else begin
                    clk_chain <= ser_clk_i;
                    dat_chain <= ser_dat_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    clk_chain <= '1;
                    dat_chain <= '0;
                end else begin
                    clk_chain <= {clk_chain[SYNC_STAGES-2:0], ser_clk_i};
                    dat_chain <= {dat_chain[SYNC_STAGES-2:0], ser_dat_i};
                end
            end
        end
    endgenerate

    // Remember the last synchronised clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_prev <= 1'b1;
        else        clk_prev <= clk_chain[SYNC_STAGES-1];
    end

    // Falling edge = high before, low now; data taken from the same stage.
    always_comb begin
        fall_o = clk_prev & ~clk_chain[SYNC_STAGES-1];
        dat_o  = dat_chain[SYNC_STAGES-1];
    end
endmodule

// File: rtl/rx_shifter.sv
// Module: rx_shifter
// Collects bits, least significant first, into a shift register and emits a
// one-cycle done pulse with the assembled word after 8 or 9 bits.
// Assumes bit_stb_i is a one-cycle strobe. Dropping run_i abandons any
// partial word.
module rx_shifter
    import sync_rx_pkg::*;
#(
    parameter int DATA_W = WORD_W
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run_i,
    input  logic     nine_i,
    input  logic     bit_stb_i,
    input  logic     bit_i,
    output logic     done_o,
    output rx_word_t word_o
);
    localparam int MAX_BITS = DATA_W + 1;
    localparam int CNT_W    = $clog2(MAX_BITS + 1);

    logic [DATA_W:0]  shreg;
    logic [DATA_W:0]  shreg_nxt;
    logic [CNT_W-1:0] bit_cnt;
    logic [CNT_W-1:0] last_idx;

    // Place the incoming bit at the current count and pick the final index.
    always_comb begin
        last_idx           = nine_i ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);
        shreg_nxt          = shreg;
        shreg_nxt[bit_cnt] = bit_i;
    end

    // Advance the bit count, and hand over the word when it is complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
            done_o  <= 1'b0;
            word_o  <= '0;
        end else if (!run_i) begin
            shreg   <= '0;
            bit_cnt <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (bit_stb_i) begin
                if (bit_cnt == last_idx) begin
                    done_o       <= 1'b1;
                    word_o.data  <= shreg_nxt[DATA_W-1:0];
                    word_o.ninth <= nine_i & shreg_nxt[DATA_W];
                    shreg        <= '0;
                    bit_cnt      <= '0;
                end else begin
                    shreg   <= shreg_nxt;
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rx_fifo.sv
// Module: rx_fifo
// A small first-in first-out holding queue for received words, with a sticky
// overrun flag. A push into a full queue, with no pop in the same cycle, is
// dropped and sets overrun. While overrun is set, pushes are refused.
// clr_ovr_i clears overrun. Assumes pop_i is asserted only when non-empty.
module rx_fifo
    import sync_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push_i,
    input  rx_word_t word_i,
    input  logic     pop_i,
    input  logic     clr_ovr_i,
    output rx_word_t head_o,
    output logic     empty_o,
    output logic     overrun_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    rx_word_t         mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             full;
    logic             do_pop;
    logic             do_push;
    logic             lose;

    // Decide what this cycle does: pop, accept a push, or lose the word.
    always_comb begin
        full    = (count == CNT_W'(DEPTH));
        empty_o = (count == '0);
        do_pop  = pop_i & ~empty_o;
        do_push = push_i & ~overrun_o & (~full | do_pop);
        lose    = push_i & ~overrun_o & full & ~do_pop;
        head_o  = empty_o ? '0 : mem[rd_ptr];
    end

    // Storage writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (do_push) begin
            mem[wr_ptr] <= word_i;
        end
    end

    // Pointer and occupancy upkeep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Sticky overrun: set on a lost word, cleared only by clr_ovr_i.
    always_ff @(posedge clk) begin
        if (!rst_n)         overrun_o <= 1'b0;
        else if (clr_ovr_i) overrun_o <= 1'b0;
        else if (lose)      overrun_o <= 1'b1;
    end
endmodule

// File: rtl/sync_slave_rx.sv
// Module: sync_slave_rx
// Receiver for a clocked serial link driven by a remote master. It samples
// data on falling serial-clock edges, assembles 8- or 9-bit words, queues
// them, and raises a receive-complete flag and a gated interrupt/wake-up
// request. Assumes the serial clock is much slower than clk.
module sync_slave_rx
    import sync_rx_pkg::*;
#(
    parameter int FIFO_DEPTH  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              sync_mode,
    input  logic              clk_src_master,
    input  logic              nine_bit_en,
    input  logic              cont_rx_en,
    input  logic              single_rx_en,
    input  logic              irq_en,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              rd_pop,
    output logic [WORD_W-1:0] data_out,
    output logic              ninth_out,
    output logic              overrun,
    output logic              rx_done,
    output logic              irq
);
    logic     rx_active;
    logic     bit_fall;
    logic     bit_val;
    logic     word_done;
    rx_word_t word_new;
    rx_word_t head;
    logic     q_empty;
    logic     unused_single;

    // Receive gate: port on, synchronous, external clock, continuous enable.
    always_comb begin
        rx_active     = port_en & sync_mode & ~clk_src_master & cont_rx_en;
        unused_single = single_rx_en;
    end

    rx_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk_i (ser_clk),
        .ser_dat_i (ser_dat),
        .fall_o    (bit_fall),
        .dat_o     (bit_val)
    );

    rx_shifter #(.DATA_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (rx_active),
        .nine_i    (nine_bit_en),
        .bit_stb_i (bit_fall),
        .bit_i     (bit_val),
        .done_o    (word_done),
        .word_o    (word_new)
    );

    rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (word_done),
        .word_i    (word_new),
        .pop_i     (rd_pop),
        .clr_ovr_i (~cont_rx_en),
        .head_o    (head),
        .empty_o   (q_empty),
        .overrun_o (overrun)
    );

    // Present the queue head and the completion/interrupt flags.
    always_comb begin
        data_out  = head.data;
        ninth_out = head.ninth;
        rx_done   = ~q_empty;
        irq       = rx_done & irq_en;
    end
endmodule

// File: rtl/sync_slave_rx_chk.sv
// Module: sync_slave_rx_chk
// Port-level properties of the slave receiver, attached through bind.
// Assumes the input discipline stated in the brief.
module sync_slave_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       port_en,
    input logic       sync_mode,
    input logic       clk_src_master,
    input logic       cont_rx_en,
    input logic       irq_en,
    input logic [7:0] data_out,
    input logic       ninth_out,
    input logic       overrun,
    input logic       rx_done,
    input logic       irq
);
    logic gate_on;

    // Receive gate as seen from the ports.
    always_comb gate_on = port_en & sync_mode & ~clk_src_master & cont_rx_en;

    // R4
    new_word_needs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> $past(gate_on, 2));

    // R6
    empty_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |-> (data_out == 8'h00 && !ninth_out));

    // R7
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    // R8
    overrun_from_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(rx_done));

    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && cont_rx_en) |=> overrun);

    // R9
    overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cont_rx_en |=> !overrun);
endmodule

bind sync_slave_rx sync_slave_rx_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .port_en        (port_en),
    .sync_mode      (sync_mode),
    .clk_src_master (clk_src_master),
    .cont_rx_en     (cont_rx_en),
    .irq_en         (irq_en),
    .data_out       (data_out),
    .ninth_out      (ninth_out),
    .overrun        (overrun),
    .rx_done        (rx_done),
    .irq            (irq)
);

// File: tb/sync_slave_rx_bench.sv
module sync_slave_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_en = 1'b0, sync_mode = 1'b0, clk_src_master = 1'b0;
    logic       nine_bit_en = 1'b0, cont_rx_en = 1'b0, single_rx_en = 1'b0;
    logic       irq_en = 1'b0, ser_clk = 1'b1, ser_dat = 1'b0, rd_pop = 1'b0;
    logic [7:0] data_out;
    logic       ninth_out, overrun, rx_done, irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sync_slave_rx u_sync_slave_rx (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .sync_mode(sync_mode),
        .clk_src_master(clk_src_master), .nine_bit_en(nine_bit_en),
        .cont_rx_en(cont_rx_en), .single_rx_en(single_rx_en), .irq_en(irq_en),
        .ser_clk(ser_clk), .ser_dat(ser_dat), .rd_pop(rd_pop),
        .data_out(data_out), .ninth_out(ninth_out), .overrun(overrun),
        .rx_done(rx_done), .irq(irq)
    );

    // Vector: {nine_bit_en, word sent (9b), expected data (8b), expected ninth}
    localparam logic [18:0] VEC [6] = '{
        {1'b0, 9'h0A5, 8'hA5, 1'b0},
        {1'b0, 9'h13C, 8'h3C, 1'b0},
        {1'b1, 9'h1FF, 8'hFF, 1'b1},
        {1'b1, 9'h055, 8'h55, 1'b0},
        {1'b0, 9'h080, 8'h80, 1'b0},
        {1'b1, 9'h101, 8'h01, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk) ser_dat = b;
        repeat (3) @(negedge clk);
        ser_clk = 1'b0;
        repeat (4) @(negedge clk);
        ser_clk = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_word(input logic [8:0] w, input int nbits);
        for (int i = 0; i < nbits; i++) send_bit(w[i]);
        repeat (6) @(negedge clk);
    endtask

    task automatic pop();
        @(negedge clk) rd_pop = 1'b1;
        @(negedge clk) rd_pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic cfg_on();
        port_en = 1'b1; sync_mode = 1'b1; clk_src_master = 1'b0; cont_rx_en = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(data_out == 8'h00 && !ninth_out, "R1 data", data_out, 0);
        chk(!overrun && !rx_done && !irq, "R1 flags", {overrun, rx_done, irq}, 0);

        // Table walk: R2 / R3 words
        cfg_on();
        for (int v = 0; v < 6; v++) begin
            nine_bit_en = VEC[v][18];
            send_word(VEC[v][17:9], VEC[v][18] ? 9 : 8);
            chk(rx_done, "R2 R3 done", rx_done, 1);
            chk(data_out == VEC[v][8:1], "R2 R3 data", data_out, VEC[v][8:1]);
            chk(ninth_out == VEC[v][0], "R3 ninth", ninth_out, VEC[v][0]);
            pop();
        end
        nine_bit_en = 1'b0;

        // R4 each gate condition off
        port_en = 1'b0;
        send_word(9'h0F0, 8);
        chk(!rx_done, "R4 port off", rx_done, 0);
        port_en = 1'b1; sync_mode = 1'b0;
        send_word(9'h0F0, 8);
        chk(!rx_done, "R4 async", rx_done, 0);
        sync_mode = 1'b1; clk_src_master = 1'b1;
        send_word(9'h0F0, 8);
        chk(!rx_done, "R4 master", rx_done, 0);
        clk_src_master = 1'b0;

        // R5 single enable ignored
        cont_rx_en = 1'b0; single_rx_en = 1'b1;
        send_word(9'h0C3, 8);
        chk(!rx_done, "R5 single only", rx_done, 0);
        cont_rx_en = 1'b1;
        send_word(9'h0C3, 8);
        chk(rx_done && data_out == 8'hC3, "R5 single set", data_out, 8'hC3);
        pop();
        single_rx_en = 1'b0;

        // R6 and R7 two-deep order, irq gating
        irq_en = 1'b0;
        send_word(9'h011, 8);
        chk(!irq, "R7 irq masked", irq, 0);
        irq_en = 1'b1;
        @(negedge clk);
        chk(irq, "R7 irq raised", irq, 1);
        send_word(9'h022, 8);
        chk(data_out == 8'h11, "R6 head first", data_out, 8'h11);
        pop();
        chk(rx_done && data_out == 8'h22, "R6 second", data_out, 8'h22);
        pop();
        chk(!rx_done && data_out == 8'h00, "R6 drained", {rx_done, data_out}, 0);
        chk(!irq, "R7 irq drop", irq, 0);

        // R8 overrun
        send_word(9'h0A1, 8);
        send_word(9'h0B2, 8);
        chk(!overrun, "R8 no overrun yet", overrun, 0);
        send_word(9'h0C4, 8);
        chk(overrun, "R8 overrun set", overrun, 1);
        chk(data_out == 8'hA1, "R8 head kept", data_out, 8'hA1);
        pop();
        chk(data_out == 8'hB2, "R8 second kept", data_out, 8'hB2);
        pop();
        send_word(9'h0D5, 8);
        chk(!rx_done, "R8 blocked", rx_done, 0);
        chk(overrun, "R9 sticky", overrun, 1);

        // R9 clear and partial-word abandon
        cont_rx_en = 1'b0;
        repeat (2) @(negedge clk);
        chk(!overrun, "R9 cleared", overrun, 0);
        cont_rx_en = 1'b1;
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        cont_rx_en = 1'b0;
        repeat (2) @(negedge clk);
        cont_rx_en = 1'b1;
        send_word(9'h05A, 8);
        chk(rx_done && data_out == 8'h5A, "R9 partial dropped", data_out, 8'h5A);
        pop();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule